// File: doc/BRIEF.md
# Unified Translation Cache with Partitioned Pinned Registers

This block translates virtual page numbers to physical page numbers for both the instruction-fetch side and the data side of a core. It holds one small, fully associative translation cache that both kinds of lookup share. Next to the cache sit two separate banks of pinned translation registers: one bank serves only instruction lookups and the other serves only data lookups. A lookup carries a kind bit (instruction or data), a region identifier and a virtual page number. One cycle later it returns a registered hit flag, the physical page number, and a flag that tells whether a pinned register supplied the result.

Software fills the cache through an insert port. Each insert carries a usage code, so the cache can hold a copy of a pinned translation and still keep that copy to one kind of lookup. Software clears the cache by address range through a purge port. It writes or clears individual pinned registers through a register port. Each entry has a size mask, and the masked low virtual page bits pass straight through to the physical page number, so one entry can cover a power-of-two group of pages.

Replacement fills free cache slots first and otherwise follows a rotating pointer. The most recently inserted entry is protected from eviction until a lookup has been satisfied by it, so the access that needed the translation can still complete.

Top module: `utlb_split`

## Requirements
- R1: After reset every cache entry and every pinned register is invalid, `res_valid` and `res_hit` are low, and any lookup misses.
- R2: A lookup presented in cycle N gives `res_valid` high in cycle N+1 and in no other cycle. A miss reports `res_hit`=0, `res_ppn`=0 and `res_from_tr`=0.
- R3: A cache entry with usage code 2'b00 (shared) satisfies both instruction and data lookups. A cache insert may evict any entry, whatever usage code that entry holds.
- R4: Usage code 2'b01 makes a cache entry instruction-only and 2'b10 makes it data-only. An entry with code 2'b11 never matches any lookup.
- R5: An entry matches when its region identifier equals the lookup's and every virtual page bit outside the entry's size mask is equal. The returned page number takes the entry's physical bits outside the mask and the lookup's virtual bits inside it.
- R6: Instruction registers (bank selected by `tr_is_data`=0) never satisfy data lookups. Data registers (`tr_is_data`=1) never satisfy instruction lookups.
- R7: A register write (`tr_purge`=0) or clear (`tr_purge`=1) changes only the entry `tr_idx` of the selected bank. The other bank is left unchanged.
- R8: When a pinned register of the lookup's kind matches, it supplies the result and `res_from_tr`=1, even if a cache entry also matches.
- R9: A cache purge invalidates every valid entry whose region identifier equals `cp_rid` and whose page range overlaps the range given by `cp_vpn`/`cp_mask`, whatever its usage code. Entries with another region identifier stay.
- R10: An insert goes to the lowest-numbered invalid slot and leaves the rotating pointer where it is. When all slots are valid, it goes to the slot the pointer names and the pointer moves to the slot after the victim.
- R11: The most recently inserted entry is skipped as a victim (the slot after it is taken) until a lookup has been satisfied by that cache entry.
- R12: Inserts and purges act from the next cycle. A lookup in the same cycle sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_is_data | input | 1 | Lookup kind: 0 instruction, 1 data |
| lk_rid | input | RID_W | Lookup region identifier |
| lk_vpn | input | PN_W | Lookup virtual page number |
| ci_valid | input | 1 | Cache insert request |
| ci_use | input | 2 | Usage code of inserted entry |
| ci_rid | input | RID_W | Inserted region identifier |
| ci_vpn | input | PN_W | Inserted virtual page number |
| ci_ppn | input | PN_W | Inserted physical page number |
| ci_mask | input | PN_W | Inserted size mask (1 = bit ignored) |
| cp_valid | input | 1 | Cache purge request |
| cp_rid | input | RID_W | Purge region identifier |
| cp_vpn | input | PN_W | Purge virtual page number |
| cp_mask | input | PN_W | Purge range mask |
| tr_valid | input | 1 | Pinned register operation |
| tr_is_data | input | 1 | Bank select: 0 instruction, 1 data |
| tr_purge | input | 1 | 1 clears the entry, 0 writes it |
| tr_idx | input | RIW | Entry index within the bank |
| tr_rid | input | RID_W | Written region identifier |
| tr_vpn | input | PN_W | Written virtual page number |
| tr_ppn | input | PN_W | Written physical page number |
| tr_mask | input | PN_W | Written size mask |
| res_valid | output | 1 | Result strobe, one cycle after a lookup |
| res_hit | output | 1 | Lookup hit |
| res_from_tr | output | 1 | Result supplied by a pinned register |
| res_ppn | output | PN_W | Translated physical page number |

## Verification
Every lookup result is due exactly one cycle after the lookup is presented. The driver pushes the expected outcome when it drives the lookup. The monitor pops one entry at each falling edge where `res_valid` is high, which is half a cycle after the result register loads. Inserts, purges and register writes are driven one cycle and take effect at the next edge. So a lookup on any later falling edge sees the new contents. The same-cycle cases in R12 drive an update and a lookup on the same edge and expect the old contents.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    typedef enum logic [1:0] {
        USE_ANY  = 2'b00,
        USE_INSN = 2'b01,
        USE_DATA = 2'b10,
        USE_NONE = 2'b11
    } use_e;

    // May an entry with usage code u serve a lookup of the given kind?
    function automatic logic use_ok(input logic [1:0] u, input logic is_data);
        case (use_e'(u))
            USE_ANY:  return 1'b1;
            USE_INSN: return !is_data;
            USE_DATA: return is_data;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/utlb_cam.sv
// Fully associative compare array. Lowest index wins on multiple matches.
module utlb_cam #(
    parameter int N     = 4,
    parameter int RID_W = 8,
    parameter int PN_W  = 20
) (
    input  logic [N-1:0]            ent_vld,
    input  logic [N-1:0]            ent_allow,
    input  logic [N-1:0][RID_W-1:0] ent_rid,
    input  logic [N-1:0][PN_W-1:0]  ent_vpn,
    input  logic [N-1:0][PN_W-1:0]  ent_msk,
    input  logic [N-1:0][PN_W-1:0]  ent_ppn,
    input  logic [RID_W-1:0]        q_rid,
    input  logic [PN_W-1:0]         q_vpn,
    output logic [N-1:0]            match,
    output logic [PN_W-1:0]         ppn
);

    for (genvar g = 0; g < N; g++) begin : g_ent
        assign match[g] = ent_vld[g] && ent_allow[g] && (ent_rid[g] == q_rid)
                          && (((ent_vpn[g] ^ q_vpn) & ~ent_msk[g]) == '0);
    end

    always_comb begin
        ppn = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                ppn = (ent_ppn[i] & ~ent_msk[i]) | (q_vpn & ent_msk[i]);
            end
        end
    end

endmodule

// File: rtl/utlb_pick.sv
// Victim choice: first free slot, else rotating pointer skipping the protected slot.
module utlb_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  slot_vld,
    input  logic [IW-1:0] rr,
    input  logic [IW-1:0] prot,
    input  logic          prot_on,
    output logic [IW-1:0] victim,
    output logic [IW-1:0] after,
    output logic          full
);

    logic [IW-1:0] free_idx;
    logic          found;
    logic [IW-1:0] rr_bump;

    always_comb begin
        full     = &slot_vld;
        free_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!slot_vld[i] && !found) begin
                free_idx = IW'(i);
                found    = 1'b1;
            end
        end
        rr_bump = (rr == IW'(N - 1)) ? '0 : rr + IW'(1);
        if (!full) begin
            victim = free_idx;
        end else if (prot_on && (rr == prot)) begin
            victim = rr_bump;
        end else begin
            victim = rr;
        end
        after = (victim == IW'(N - 1)) ? '0 : victim + IW'(1);
    end

endmodule

// File: rtl/utlb_split.sv
module utlb_split #(
    parameter int NC    = 4,
    parameter int NR    = 2,
    parameter int RID_W = 8,
    parameter int PN_W  = 20,
    localparam int CIW  = (NC > 1) ? $clog2(NC) : 1,
    localparam int RIW  = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_is_data,
    input  logic [RID_W-1:0] lk_rid,
    input  logic [PN_W-1:0]  lk_vpn,
    input  logic             ci_valid,
    input  logic [1:0]       ci_use,
    input  logic [RID_W-1:0] ci_rid,
    input  logic [PN_W-1:0]  ci_vpn,
    input  logic [PN_W-1:0]  ci_ppn,
    input  logic [PN_W-1:0]  ci_mask,
    input  logic             cp_valid,
    input  logic [RID_W-1:0] cp_rid,
    input  logic [PN_W-1:0]  cp_vpn,
    input  logic [PN_W-1:0]  cp_mask,
    input  logic             tr_valid,
    input  logic             tr_is_data,
    input  logic             tr_purge,
    input  logic [RIW-1:0]   tr_idx,
    input  logic [RID_W-1:0] tr_rid,
    input  logic [PN_W-1:0]  tr_vpn,
    input  logic [PN_W-1:0]  tr_ppn,
    input  logic [PN_W-1:0]  tr_mask,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_from_tr,
    output logic [PN_W-1:0]  res_ppn
);
    import utlb_pkg::*;

    typedef struct packed {
        logic [NC-1:0]                  c_vld;
        logic [NC-1:0][1:0]             c_use;
        logic [NC-1:0][RID_W-1:0]       c_rid;
        logic [NC-1:0][PN_W-1:0]        c_vpn;
        logic [NC-1:0][PN_W-1:0]        c_ppn;
        logic [NC-1:0][PN_W-1:0]        c_msk;
        logic [1:0][NR-1:0]             t_vld;
        logic [1:0][NR-1:0][RID_W-1:0]  t_rid;
        logic [1:0][NR-1:0][PN_W-1:0]   t_vpn;
        logic [1:0][NR-1:0][PN_W-1:0]   t_ppn;
        logic [1:0][NR-1:0][PN_W-1:0]   t_msk;
        logic [CIW-1:0]                 rr;
        logic [CIW-1:0]                 prot;
        logic                           prot_on;
        logic                           r_vld;
        logic                           r_hit;
        logic                           r_tr;
        logic [PN_W-1:0]                r_ppn;
    } state_t;

    state_t st_q, st_d;

    // cache compare
    logic [NC-1:0]   c_allow;
    logic [NC-1:0]   c_match;
    logic [PN_W-1:0] c_ppn;
    logic            c_any;

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            c_allow[i] = use_ok(st_q.c_use[i], lk_is_data);
        end
    end

    utlb_cam #(.N(NC), .RID_W(RID_W), .PN_W(PN_W)) u_ccam (
        .ent_vld  (st_q.c_vld),
        .ent_allow(c_allow),
        .ent_rid  (st_q.c_rid),
        .ent_vpn  (st_q.c_vpn),
        .ent_msk  (st_q.c_msk),
        .ent_ppn  (st_q.c_ppn),
        .q_rid    (lk_rid),
        .q_vpn    (lk_vpn),
        .match    (c_match),
        .ppn      (c_ppn)
    );
    assign c_any = |c_match;

    // pinned register banks: index 0 instruction, 1 data
    logic [1:0][NR-1:0]   t_match;
    logic [1:0][PN_W-1:0] t_ppn;

    for (genvar s = 0; s < 2; s++) begin : g_bank
        utlb_cam #(.N(NR), .RID_W(RID_W), .PN_W(PN_W)) u_tcam (
            .ent_vld  (st_q.t_vld[s]),
            .ent_allow({NR{1'b1}}),
            .ent_rid  (st_q.t_rid[s]),
            .ent_vpn  (st_q.t_vpn[s]),
            .ent_msk  (st_q.t_msk[s]),
            .ent_ppn  (st_q.t_ppn[s]),
            .q_rid    (lk_rid),
            .q_vpn    (lk_vpn),
            .match    (t_match[s]),
            .ppn      (t_ppn[s])
        );
    end

    logic            t_hit;
    logic [PN_W-1:0] t_sel_ppn;
    assign t_hit     = |t_match[lk_is_data];
    assign t_sel_ppn = t_ppn[lk_is_data];

    // replacement
    logic [CIW-1:0] victim;
    logic [CIW-1:0] after;
    logic           c_full;

    utlb_pick #(.N(NC), .IW(CIW)) u_pick (
        .slot_vld(st_q.c_vld),
        .rr      (st_q.rr),
        .prot    (st_q.prot),
        .prot_on (st_q.prot_on),
        .victim  (victim),
        .after   (after),
        .full    (c_full)
    );

    always_comb begin
        st_d = st_q;

        // registered lookup result
        st_d.r_vld = lk_valid;
        st_d.r_hit = lk_valid && (t_hit || c_any);
        st_d.r_tr  = lk_valid && t_hit;
        if (!lk_valid) begin
            st_d.r_ppn = '0;
        end else if (t_hit) begin
            st_d.r_ppn = t_sel_ppn;
        end else if (c_any) begin
            st_d.r_ppn = c_ppn;
        end else begin
            st_d.r_ppn = '0;
        end

        // protection lifts once the protected cache entry served a lookup
        if (lk_valid && !t_hit && st_q.prot_on && c_match[st_q.prot]) begin
            st_d.prot_on = 1'b0;
        end

        // range purge, any usage code
        if (cp_valid) begin
            for (int i = 0; i < NC; i++) begin
                if (st_q.c_vld[i] && (st_q.c_rid[i] == cp_rid)
                    && (((st_q.c_vpn[i] ^ cp_vpn) & ~(st_q.c_msk[i] | cp_mask)) == '0)) begin
                    st_d.c_vld[i] = 1'b0;
                end
            end
        end

        // insert (written after the purge)
        if (ci_valid) begin
            st_d.c_vld[victim] = 1'b1;
            st_d.c_use[victim] = ci_use;
            st_d.c_rid[victim] = ci_rid;
            st_d.c_vpn[victim] = ci_vpn;
            st_d.c_ppn[victim] = ci_ppn;
            st_d.c_msk[victim] = ci_mask;
            st_d.prot          = victim;
            st_d.prot_on       = 1'b1;
            if (c_full) begin
                st_d.rr = after;
            end
        end

        // pinned register write or clear
        if (tr_valid) begin
            if (tr_purge) begin
                st_d.t_vld[tr_is_data][tr_idx] = 1'b0;
            end else begin
                st_d.t_vld[tr_is_data][tr_idx] = 1'b1;
                st_d.t_rid[tr_is_data][tr_idx] = tr_rid;
                st_d.t_vpn[tr_is_data][tr_idx] = tr_vpn;
                st_d.t_ppn[tr_is_data][tr_idx] = tr_ppn;
                st_d.t_msk[tr_is_data][tr_idx] = tr_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid   = st_q.r_vld;
    assign res_hit     = st_q.r_hit;
    assign res_from_tr = st_q.r_tr;
    assign res_ppn     = st_q.r_ppn;

endmodule

// File: rtl/utlb_split_chk.sv
module utlb_split_chk #(
    parameter int NC   = 4,
    parameter int NR   = 2,
    parameter int PN_W = 20,
    parameter int CIW  = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic            res_valid,
    input logic            res_hit,
    input logic            res_from_tr,
    input logic [PN_W-1:0] res_ppn,
    input logic [NC-1:0]   c_match,
    input logic            ci_valid,
    input logic            cache_full,
    input logic            prot_on,
    input logic [CIW-1:0]  victim,
    input logic [CIW-1:0]  prot,
    input logic            tr_valid,
    input logic            tr_is_data,
    input logic [NR-1:0]   itr_vld,
    input logic [NR-1:0]   dtr_vld
);

    assert_result_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_miss_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_ppn == '0 && !res_from_tr));

    assert_tr_is_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_from_tr |-> (res_hit && res_valid));

    // overlapping cache entries are a software error; flag them
    assert_single_cache_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(c_match));

    assert_protected_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ci_valid && cache_full && prot_on) |-> (victim != prot));

    assert_dbank_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && !tr_is_data) |=> $stable(dtr_vld));

    assert_ibank_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && tr_is_data) |=> $stable(itr_vld));

endmodule

bind utlb_split utlb_split_chk #(.NC(NC), .NR(NR), .PN_W(PN_W), .CIW(CIW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_from_tr(res_from_tr),
    .res_ppn    (res_ppn),
    .c_match    (c_match),
    .ci_valid   (ci_valid),
    .cache_full (c_full),
    .prot_on    (st_q.prot_on),
    .victim     (victim),
    .prot       (st_q.prot),
    .tr_valid   (tr_valid),
    .tr_is_data (tr_is_data),
    .itr_vld    (st_q.t_vld[0]),
    .dtr_vld    (st_q.t_vld[1])
);

// File: tb/sim_utlb_split.sv
module sim_utlb_split;

    localparam int RID_W = 8;
    localparam int PN_W  = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0, lk_is_data = 1'b0;
    logic [RID_W-1:0] lk_rid = '0;
    logic [PN_W-1:0]  lk_vpn = '0;
    logic             ci_valid = 1'b0;
    logic [1:0]       ci_use = '0;
    logic [RID_W-1:0] ci_rid = '0;
    logic [PN_W-1:0]  ci_vpn = '0, ci_ppn = '0, ci_mask = '0;
    logic             cp_valid = 1'b0;
    logic [RID_W-1:0] cp_rid = '0;
    logic [PN_W-1:0]  cp_vpn = '0, cp_mask = '0;
    logic             tr_valid = 1'b0, tr_is_data = 1'b0, tr_purge = 1'b0;
    logic [0:0]       tr_idx = '0;
    logic [RID_W-1:0] tr_rid = '0;
    logic [PN_W-1:0]  tr_vpn = '0, tr_ppn = '0, tr_mask = '0;
    logic             res_valid, res_hit, res_from_tr;
    logic [PN_W-1:0]  res_ppn;

    always #5 clk = ~clk;

    utlb_split u0 (.*);

    typedef struct {
        logic            hit;
        logic [PN_W-1:0] ppn;
        logic            tr;
        string           tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    localparam logic I = 1'b0, D = 1'b1;

    task automatic set_look(input logic d, input logic [RID_W-1:0] rid, input logic [PN_W-1:0] vpn,
                            input logic eh, input logic [PN_W-1:0] ep, input logic et, input string tag);
        exp_t e;
        lk_valid = 1'b1; lk_is_data = d; lk_rid = rid; lk_vpn = vpn;
        e.hit = eh; e.ppn = ep; e.tr = et; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic set_ins(input logic [1:0] u, input logic [RID_W-1:0] rid, input logic [PN_W-1:0] vpn,
                           input logic [PN_W-1:0] ppn, input logic [PN_W-1:0] msk);
        ci_valid = 1'b1; ci_use = u; ci_rid = rid; ci_vpn = vpn; ci_ppn = ppn; ci_mask = msk;
    endtask

    task automatic set_purge(input logic [RID_W-1:0] rid, input logic [PN_W-1:0] vpn, input logic [PN_W-1:0] msk);
        cp_valid = 1'b1; cp_rid = rid; cp_vpn = vpn; cp_mask = msk;
    endtask

    task automatic pulse();
        @(negedge clk);
        lk_valid = 1'b0; ci_valid = 1'b0; cp_valid = 1'b0; tr_valid = 1'b0;
    endtask

    task automatic look(input logic d, input logic [PN_W-1:0] vpn, input logic eh,
                        input logic [PN_W-1:0] ep, input logic et, input string tag);
        @(negedge clk); set_look(d, 8'd5, vpn, eh, ep, et, tag); pulse();
    endtask

    task automatic cins(input logic [1:0] u, input logic [PN_W-1:0] vpn, input logic [PN_W-1:0] ppn,
                        input logic [PN_W-1:0] msk);
        @(negedge clk); set_ins(u, 8'd5, vpn, ppn, msk); pulse();
    endtask

    task automatic cpurge(input logic [RID_W-1:0] rid, input logic [PN_W-1:0] vpn, input logic [PN_W-1:0] msk);
        @(negedge clk); set_purge(rid, vpn, msk); pulse();
    endtask

    task automatic trw(input logic d, input logic idx, input logic pg, input logic [PN_W-1:0] vpn,
                       input logic [PN_W-1:0] ppn);
        @(negedge clk);
        tr_valid = 1'b1; tr_is_data = d; tr_idx = idx; tr_purge = pg;
        tr_rid = 8'd5; tr_vpn = vpn; tr_ppn = ppn; tr_mask = '0;
        pulse();
    endtask

    // monitor: results are due one cycle after each lookup
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                n_chk++;
                if (q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2 unexpected result: hit=%0b ppn=%h expected no result", res_hit, res_ppn);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (res_hit !== e.hit || res_ppn !== e.ppn || res_from_tr !== e.tr) begin
                        n_bad++;
                        $display("FAIL %s: hit=%0b ppn=%h tr=%0b expected hit=%0b ppn=%h tr=%0b",
                                 e.tag, res_hit, res_ppn, res_from_tr, e.hit, e.ppn, e.tr);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: valid=%0b hit=%0b expected 0 0", res_valid, res_hit);
        end
        look(I, 20'h00100, 0, 20'h0, 0, "R1 empty miss");

        cins(2'b00, 20'h00100, 20'h00ABC, 20'h0);
        look(I, 20'h00100, 1, 20'h00ABC, 0, "R3 shared insn");
        look(D, 20'h00100, 1, 20'h00ABC, 0, "R3 shared data");

        cins(2'b01, 20'h00200, 20'h00222, 20'h0);
        look(I, 20'h00200, 1, 20'h00222, 0, "R4 insn-only insn");
        look(D, 20'h00200, 0, 20'h0, 0, "R4 insn-only data");
        cins(2'b10, 20'h00300, 20'h00333, 20'h0);
        look(D, 20'h00300, 1, 20'h00333, 0, "R4 data-only data");
        look(I, 20'h00300, 0, 20'h0, 0, "R4 data-only insn");

        cins(2'b00, 20'h00400, 20'h05550, 20'h0000F);
        look(D, 20'h00407, 1, 20'h05557, 0, "R5 masked merge");
        @(negedge clk); set_look(I, 8'd6, 20'h00407, 0, 20'h0, 0, "R5 rid mismatch"); pulse();
        look(I, 20'h00417, 0, 20'h0, 0, "R5 outside mask");

        // full: rotating pointer at slot 0 evicts the first entry
        cins(2'b00, 20'h00500, 20'h00555, 20'h0);
        look(I, 20'h00100, 0, 20'h0, 0, "R10 rotate evicts");
        look(I, 20'h00500, 1, 20'h00555, 0, "R10 new entry");

        cpurge(8'd5, 20'h00200, 20'h0);
        look(I, 20'h00200, 0, 20'h0, 0, "R9 purge exact");

        cins(2'b00, 20'h00600, 20'h00666, 20'h0);   // fills freed slot, pointer stays
        cins(2'b10, 20'h00700, 20'h00777, 20'h0);   // pointer slot is protected, next taken
        look(I, 20'h00600, 1, 20'h00666, 0, "R11 protected kept");
        look(D, 20'h00300, 0, 20'h0, 0, "R11 next slot evicted");
        look(D, 20'h00700, 1, 20'h00777, 0, "R11 newest present");

        cpurge(8'd5, 20'h00700, 20'h0);
        look(D, 20'h00700, 0, 20'h0, 0, "R9 purge data-only");
        cpurge(8'd5, 20'h00405, 20'h0);
        look(D, 20'h00407, 0, 20'h0, 0, "R9 purge overlap");
        cpurge(8'd6, 20'h00500, 20'h0);
        look(I, 20'h00500, 1, 20'h00555, 0, "R9 other rid kept");

        trw(I, 1'b0, 1'b0, 20'h00800, 20'h00888);
        look(I, 20'h00800, 1, 20'h00888, 1, "R6 ibank insn");
        look(D, 20'h00800, 0, 20'h0, 0, "R6 ibank data");
        trw(D, 1'b0, 1'b0, 20'h00900, 20'h00999);
        look(D, 20'h00900, 1, 20'h00999, 1, "R6 dbank data");
        look(I, 20'h00900, 0, 20'h0, 0, "R6 dbank insn");

        trw(D, 1'b1, 1'b0, 20'h00800, 20'h008D8);
        look(D, 20'h00800, 1, 20'h008D8, 1, "R7 dbank write");
        look(I, 20'h00800, 1, 20'h00888, 1, "R7 ibank kept");
        trw(I, 1'b0, 1'b1, 20'h0, 20'h0);
        look(I, 20'h00800, 0, 20'h0, 0, "R7 ibank clear");
        look(D, 20'h00800, 1, 20'h008D8, 1, "R7 dbank kept");
        trw(I, 1'b1, 1'b0, 20'h00C00, 20'h00CCC);
        trw(D, 1'b1, 1'b1, 20'h0, 20'h0);
        look(I, 20'h00C00, 1, 20'h00CCC, 1, "R7 ibank kept on dbank clear");
        look(D, 20'h00800, 0, 20'h0, 0, "R7 dbank clear");

        cins(2'b00, 20'h00900, 20'h00111, 20'h0);
        look(D, 20'h00900, 1, 20'h00999, 1, "R8 register wins");
        look(I, 20'h00900, 1, 20'h00111, 0, "R8 cache when no register");

        @(negedge clk);
        set_ins(2'b00, 8'd5, 20'h00A00, 20'h00AAA, 20'h0);
        set_look(I, 8'd5, 20'h00A00, 0, 20'h0, 0, "R12 insert same cycle");
        pulse();
        look(I, 20'h00A00, 1, 20'h00AAA, 0, "R12 insert next cycle");
        @(negedge clk);
        set_purge(8'd5, 20'h00500, 20'h0);
        set_look(I, 8'd5, 20'h00500, 1, 20'h00555, 0, "R12 purge same cycle");
        pulse();
        look(I, 20'h00500, 0, 20'h0, 0, "R12 purge next cycle");

        cins(2'b11, 20'h00B00, 20'h00BBB, 20'h0);
        look(I, 20'h00B00, 0, 20'h0, 0, "R4 code 11 insn");
        look(D, 20'h00B00, 0, 20'h0, 0, "R4 code 11 data");

        repeat (3) @(negedge clk);
        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 missing results: %0d pending expected 0", q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule